// File: doc/BRIEF.md
# Transmitter Table Manager

This block keeps a small table of learned remote-control transmitters in an external memory that is read and written one 16-bit word at a time. Each entry identifies a transmitter by its 28-bit serial number, keeps the 4-bit button code that was used when it was learned, and holds its 16-bit synchronisation counter twice. A command port offers five operations: look up a serial number, add a new transmitter in the first free entry, overwrite the counter of an entry, read the counter back while checking that its two copies agree, and wipe the whole table. Entries cannot be removed one at a time.

A free entry is recognised by a reserved value, 0xF0, in its first byte, where a learned entry holds the button code and the top serial-number nibble. Lookup and insertion walk the entries in order from entry 0, so the cost of a command grows linearly with the table size. The memory answers a read one cycle after it is requested. The block waits for each read word before it acts on it.

A host starts a command when `busy` is low and waits for the one-cycle `done` pulse. The result flags are then valid and they stay unchanged until the next command is accepted.

Top module: `xmit_table`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done`, `found`, `full`, `mismatch`, `mem_rd` and `mem_wr` are all low.
- R2: Entry n occupies byte addresses 8n to 8n+7 and is accessed as four words at byte addresses 8n+2w, w=0..3. Word 0 is {func[3:0], sn[27:24], sn[7:0]}. Word 1 is {sn[15:8], sn[23:16]}. Words 2 and 3 each hold the sync counter.
- R3: Find (`cmd_op`=0) scans from entry 0 upward. On a match it raises `found` and sets `rec_idx` to the lowest entry that is not free and whose serial number equals `cmd_sn`. The button code is ignored in the comparison.
- R4: When no entry matches, find completes with `found` low and `full` low, and it writes no memory.
- R5: Insert (`cmd_op`=1) writes words 0 to 3 of the lowest entry whose word-0 high byte is 0xF0. The new entry gets `cmd_func`, `cmd_sn` and `cmd_sync` in both copies. `rec_idx` reports that entry and `full` stays low.
- R6: When no entry is free, insert completes with `full` high and writes no memory.
- R7: An insert whose {`cmd_func`, `cmd_sn[27:24]`} equals 0xF0 is rejected. It completes with `found` and `full` low and writes no memory, even when free entries exist.
- R8: Update (`cmd_op`=2) writes `cmd_sync` into words 2 and 3 of entry `cmd_rec` and writes nothing else.
- R9: Read-sync (`cmd_op`=3) reads words 2 and 3 of entry `cmd_rec`. It presents word 2 on `sync_out` and raises `mismatch` exactly when the two words differ.
- R10: Erase (`cmd_op`=4) writes 0xF000 into word 0 of every entry, one write per entry, and writes no other word.
- R11: A command is accepted only when `cmd_valid` is high while `busy` is low. `busy` stays high from the cycle after acceptance through a single-cycle `done` pulse. A request made while busy is ignored. The flags are held from `done` until the next acceptance.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle, and neither is high while idle. Read data is taken from `mem_rdata` one cycle after `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Operation: 0 find, 1 insert, 2 update, 3 read-sync, 4 erase |
| cmd_func | input | 4 | Button code for insert |
| cmd_sn | input | 28 | Serial number for find and insert |
| cmd_sync | input | 16 | Sync counter for insert and update |
| cmd_rec | input | 4 | Entry index for update and read-sync |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Find located a match |
| full | output | 1 | Insert found no free entry |
| mismatch | output | 1 | Sync copies differ |
| rec_idx | output | 4 | Entry matched by find or written by insert |
| sync_out | output | 16 | First sync copy read by read-sync |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 7 | Byte address, always even |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |

## Verification
The bench targets six corner cases.
- Free entries scattered among learned ones: a scan that fails to skip a free slot, or skips past the lowest one, would return the wrong index or overwrite a live entry.
- A serial number whose top nibble sits beside the reserved marker: a design that compares whole bytes, or accepts the marker on insert, would match a free slot or create an entry that reads back as empty.
- A table with every entry in use: this exposes inserts that write despite reporting full.
- A deliberately corrupted second sync copy: this catches a read-sync that compares the wrong words or reports the wrong copy.
- Requests made while a command is running: a design that accepted them would start an unwanted erase.
- A full shadow image of the memory, compared after every command: this catches stray writes that no flag would reveal.

// File: rtl/xmit_table_pkg.sv
package xmit_table_pkg;

    typedef enum logic [2:0] {
        OP_FIND   = 3'd0,
        OP_INSERT = 3'd1,
        OP_UPDATE = 3'd2,
        OP_RDSYNC = 3'd3,
        OP_ERASE  = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN_RD,
        S_SCAN_CHK,
        S_WRITE,
        S_SYNC_RD,
        S_SYNC_CHK,
        S_DONE
    } state_e;

    typedef struct packed {
        logic [3:0]  func;
        logic [27:0] sn;
    } ident_t;

    localparam logic [7:0]  FREE_MARK = 8'hF0;
    localparam logic [15:0] FREE_WORD = {FREE_MARK, 8'h00};

    function automatic logic [7:0] head_byte(ident_t id);
        return {id.func, id.sn[27:24]};
    endfunction

endpackage

// File: rtl/xt_rec_match.sv
module xt_rec_match
    import xmit_table_pkg::*;
(
    input  logic [15:0] word,
    input  logic        second,
    input  logic [27:0] key,
    output logic        is_free,
    output logic        part_hit
);
    always_comb begin
        is_free = (word[15:8] == FREE_MARK);
        if (second)
            part_hit = (word == {key[15:8], key[23:16]});
        else
            part_hit = !is_free && (word[11:8] == key[27:24]) && (word[7:0] == key[7:0]);
    end
endmodule

// File: rtl/xt_rec_pack.sv
module xt_rec_pack
    import xmit_table_pkg::*;
(
    input  ident_t      id,
    input  logic [15:0] sync,
    input  logic [1:0]  wsel,
    input  logic        wipe,
    output logic [15:0] wdata
);
    always_comb begin
        if (wipe) begin
            wdata = FREE_WORD;
        end else begin
            unique case (wsel)
                2'd0:    wdata = {head_byte(id), id.sn[7:0]};
                2'd1:    wdata = {id.sn[15:8], id.sn[23:16]};
                default: wdata = sync;
            endcase
        end
    end
endmodule

// File: rtl/xmit_table.sv
module xmit_table
    import xmit_table_pkg::*;
#(
    parameter int NUM_REC = 16,
    localparam int REC_W  = (NUM_REC > 1) ? $clog2(NUM_REC) : 1,
    localparam int ADDR_W = REC_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [3:0]        cmd_func,
    input  logic [27:0]       cmd_sn,
    input  logic [15:0]       cmd_sync,
    input  logic [REC_W-1:0]  cmd_rec,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic              full,
    output logic              mismatch,
    output logic [REC_W-1:0]  rec_idx,
    output logic [15:0]       sync_out,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata
);
    localparam logic [REC_W-1:0] LAST_REC = REC_W'(NUM_REC - 1);

    state_e            state;
    op_e               op;
    ident_t            id;
    logic [15:0]       sync_r;
    logic [15:0]       first_copy;
    logic [REC_W-1:0]  rec;
    logic [1:0]        wsel;
    logic              is_free;
    logic              part_hit;
    ident_t            cmd_id;

    assign cmd_id = '{func: cmd_func, sn: cmd_sn};

    xt_rec_match u_match (
        .word     (mem_rdata),
        .second   (wsel[0]),
        .key      (id.sn),
        .is_free  (is_free),
        .part_hit (part_hit)
    );

    xt_rec_pack u_pack (
        .id    (id),
        .sync  (sync_r),
        .wsel  (wsel),
        .wipe  (op == OP_ERASE),
        .wdata (mem_wdata)
    );

    assign busy     = (state != S_IDLE);
    assign done     = (state == S_DONE);
    assign mem_rd   = (state == S_SCAN_RD) || (state == S_SYNC_RD);
    assign mem_wr   = (state == S_WRITE);
    assign mem_addr = {rec, wsel, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            op         <= OP_FIND;
            id         <= '0;
            sync_r     <= '0;
            first_copy <= '0;
            rec        <= '0;
            wsel       <= '0;
            found      <= 1'b0;
            full       <= 1'b0;
            mismatch   <= 1'b0;
            rec_idx    <= '0;
            sync_out   <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        op       <= op_e'(cmd_op);
                        id       <= cmd_id;
                        sync_r   <= cmd_sync;
                        found    <= 1'b0;
                        full     <= 1'b0;
                        mismatch <= 1'b0;
                        unique case (op_e'(cmd_op))
                            OP_FIND: begin
                                rec <= '0; wsel <= 2'd0; state <= S_SCAN_RD;
                            end
                            OP_INSERT: begin
                                rec <= '0; wsel <= 2'd0;
                                state <= (head_byte(cmd_id) == FREE_MARK) ? S_DONE : S_SCAN_RD;
                            end
                            OP_UPDATE: begin
                                rec <= cmd_rec; wsel <= 2'd2; state <= S_WRITE;
                            end
                            OP_RDSYNC: begin
                                rec <= cmd_rec; wsel <= 2'd2; state <= S_SYNC_RD;
                            end
                            OP_ERASE: begin
                                rec <= '0; wsel <= 2'd0; state <= S_WRITE;
                            end
                            default: state <= S_DONE;
                        endcase
                    end
                end
                S_SCAN_RD: state <= S_SCAN_CHK;
                S_SCAN_CHK: begin
                    if (op == OP_INSERT && is_free) begin
                        rec_idx <= rec;
                        wsel    <= 2'd0;
                        state   <= S_WRITE;
                    end else if (op == OP_FIND && part_hit && !wsel[0]) begin
                        wsel  <= 2'd1;
                        state <= S_SCAN_RD;
                    end else if (op == OP_FIND && part_hit) begin
                        found   <= 1'b1;
                        rec_idx <= rec;
                        state   <= S_DONE;
                    end else if (rec == LAST_REC) begin
                        full  <= (op == OP_INSERT);
                        state <= S_DONE;
                    end else begin
                        rec   <= rec + 1'b1;
                        wsel  <= 2'd0;
                        state <= S_SCAN_RD;
                    end
                end
                S_WRITE: begin
                    if (op == OP_ERASE) begin
                        if (rec == LAST_REC) state <= S_DONE;
                        else                 rec   <= rec + 1'b1;
                    end else if (wsel == 2'd3) begin
                        state <= S_DONE;
                    end else begin
                        wsel <= wsel + 2'd1;
                    end
                end
                S_SYNC_RD: state <= S_SYNC_CHK;
                S_SYNC_CHK: begin
                    if (wsel == 2'd2) begin
                        first_copy <= mem_rdata;
                        wsel       <= 2'd3;
                        state      <= S_SYNC_RD;
                    end else begin
                        sync_out <= first_copy;
                        mismatch <= (first_copy != mem_rdata);
                        state    <= S_DONE;
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xmit_table_chk.sv
module xmit_table_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              busy,
    input logic              done,
    input logic              found,
    input logic              full,
    input logic              mismatch,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr
);
    a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_rd || mem_wr));

    a_r11_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_start_on_req: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid));

    a_r6_full_not_found: assert property (@(posedge clk) disable iff (rst)
        done |-> !(found && full));

    a_r9_mismatch_at_done: assert property (@(posedge clk) disable iff (rst)
        $rose(mismatch) |-> done);

    a_r2_even_address: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> !mem_addr[0]);
endmodule

bind xmit_table xmit_table_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .found     (found),
    .full      (full),
    .mismatch  (mismatch),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr)
);

// File: tb/xmit_table_tb_top.sv
`timescale 1ns/1ps
module xmit_table_tb_top;
    localparam int NREC  = 16;
    localparam int NWORD = NREC * 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [3:0]  cmd_func = '0;
    logic [27:0] cmd_sn = '0;
    logic [15:0] cmd_sync = '0;
    logic [3:0]  cmd_rec = '0;
    logic        busy, done, found, full, mismatch, mem_rd, mem_wr;
    logic [3:0]  rec_idx;
    logic [15:0] sync_out, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [6:0]  mem_addr;

    logic        poke_en = 1'b0;
    logic [5:0]  poke_a = '0;
    logic [15:0] poke_d = '0;
    logic [15:0] mem    [0:NWORD-1];
    logic [15:0] shadow [0:NWORD-1];

    int n_checks = 0;
    int n_fail   = 0;
    int wr_count = 0;
    int clash    = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xmit_table #(.NUM_REC(NREC)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_func(cmd_func), .cmd_sn(cmd_sn), .cmd_sync(cmd_sync), .cmd_rec(cmd_rec),
        .busy(busy), .done(done), .found(found), .full(full), .mismatch(mismatch),
        .rec_idx(rec_idx), .sync_out(sync_out), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model: one-cycle read latency (R12)
    always @(posedge clk) begin
        if (poke_en)     mem[poke_a] <= poke_d;
        else if (mem_wr) mem[mem_addr[6:1]] <= mem_wdata;
        if (mem_rd)      mem_rdata <= mem[mem_addr[6:1]];
        if (mem_wr) wr_count <= wr_count + 1;
        if (mem_wr && mem_rd) clash <= clash + 1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_find(input logic [27:0] sn);
        for (int r = 0; r < NREC; r++) begin
            if (shadow[r*4][15:8] != 8'hF0 &&
                shadow[r*4][11:8] == sn[27:24] && shadow[r*4][7:0] == sn[7:0] &&
                shadow[r*4+1] == {sn[15:8], sn[23:16]})
                return r;
        end
        return -1;
    endfunction

    function automatic int exp_free();
        for (int r = 0; r < NREC; r++)
            if (shadow[r*4][15:8] == 8'hF0) return r;
        return -1;
    endfunction

    task automatic poke(input int a, input logic [15:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_a = 6'(a); poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
        shadow[a] = d;
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [3:0] f, input logic [27:0] sn,
                           input logic [15:0] sy, input logic [3:0] r);
        int t;
        @(negedge clk);
        wr_count = 0;
        cmd_op = op; cmd_func = f; cmd_sn = sn; cmd_sync = sy; cmd_rec = r;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        t = 0;
        while (!done && t < 1000) begin
            @(negedge clk);
            t++;
        end
        check(done, "R11 done reached", 32'(done), 1);
    endtask

    task automatic mem_cmp(input string tag);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < NWORD; i++)
            if (mem[i] !== shadow[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        check(bad == 0, tag, 32'(first), 32'hFFFFFFFF);
    endtask

    task automatic do_insert(input logic [3:0] f, input logic [27:0] sn, input logic [15:0] sy);
        int slot = exp_free();
        run_cmd(3'd1, f, sn, sy, 4'd0);
        if (slot >= 0) begin
            check(!full && rec_idx == 4'(slot), "R5 insert slot", {27'd0, full, rec_idx}, 32'(slot));
            check(wr_count == 4, "R5 insert writes", 32'(wr_count), 4);
            shadow[slot*4]   = {f, sn[27:24], sn[7:0]};
            shadow[slot*4+1] = {sn[15:8], sn[23:16]};
            shadow[slot*4+2] = sy;
            shadow[slot*4+3] = sy;
            mem_cmp("R2 layout after insert");
        end else begin
            check(full && !found, "R6 full flag", {30'd0, full, found}, 32'h2);
            check(wr_count == 0, "R6 no write when full", 32'(wr_count), 0);
        end
    endtask

    task automatic do_find(input logic [27:0] sn);
        int e = exp_find(sn);
        run_cmd(3'd0, 4'd0, sn, 16'd0, 4'd0);
        if (e >= 0)
            check(found && rec_idx == 4'(e), "R3 find hit", {27'd0, found, rec_idx}, {27'd0, 1'b1, 4'(e)});
        else
            check(!found && !full && wr_count == 0, "R4 find miss", {30'd0, found, full}, 0);
    endtask

    logic [27:0] sns [0:NREC-1];

    initial begin
        void'($urandom(32'd7319));
        // clear memory model
        for (int i = 0; i < NWORD; i++) poke(i, 16'h0000);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !found && !full && !mismatch && !mem_rd && !mem_wr,
              "R1 reset state", {25'd0, busy, done, found, full, mismatch, mem_rd, mem_wr}, 0);

        // R10 erase
        run_cmd(3'd4, 4'd0, 28'd0, 16'd0, 4'd0);
        check(wr_count == NREC, "R10 erase write count", 32'(wr_count), NREC);
        for (int r = 0; r < NREC; r++) shadow[r*4] = 16'hF000;
        mem_cmp("R10 erase image");

        // R7 reserved head byte rejected even with free slots
        run_cmd(3'd1, 4'hF, 28'h0ABCDEF, 16'h1234, 4'd0);
        check(!found && !full && wr_count == 0, "R7 marker insert rejected",
              {30'd0, found, full} | 32'(wr_count << 4), 0);
        mem_cmp("R7 image unchanged");

        // R5 fill the table; one entry has func F with nonzero top nibble
        for (int i = 0; i < NREC; i++) begin
            sns[i] = 28'($urandom());
            if (i == 2) sns[i] = 28'h1000001;
            do_insert((i == 2) ? 4'hF : 4'($urandom_range(0, 14)), sns[i], 16'($urandom()));
        end
        // R6 table full
        do_insert(4'h3, 28'h5555555, 16'h0001);
        mem_cmp("R6 image unchanged");

        // R3 / R4 random and directed lookups
        for (int k = 0; k < 24; k++) begin
            if ($urandom_range(0, 3) == 0) do_find(28'($urandom()));
            else                           do_find(sns[$urandom_range(0, NREC - 1)]);
        end
        do_find(sns[NREC-1]);
        do_find(sns[0] ^ 28'h1000000);   // differs only in top nibble
        do_find(sns[0] ^ 28'h0000100);   // differs only in second word

        // R8 update
        run_cmd(3'd2, 4'd0, 28'd0, 16'hBEEF, 4'd5);
        check(wr_count == 2, "R8 update writes", 32'(wr_count), 2);
        shadow[22] = 16'hBEEF; shadow[23] = 16'hBEEF;
        mem_cmp("R8 update image");

        // R9 read-sync, agreeing then corrupted
        run_cmd(3'd3, 4'd0, 28'd0, 16'd0, 4'd5);
        check(sync_out == 16'hBEEF && !mismatch, "R9 sync read", {15'd0, mismatch, sync_out}, 32'hBEEF);
        poke(23, 16'hBEEE);
        run_cmd(3'd3, 4'd0, 28'd0, 16'd0, 4'd5);
        check(sync_out == 16'hBEEF && mismatch, "R9 mismatch", {15'd0, mismatch, sync_out}, 32'h1BEEF);
        check(wr_count == 0, "R9 no writes", 32'(wr_count), 0);

        // R5 lowest free slot after freeing entries 3 and 9
        poke(12, 16'hF000);
        poke(36, 16'hF000);
        do_find(sns[3]);
        do_insert(4'h7, 28'h2468ACE, 16'h0042);
        do_insert(4'h1, 28'h1357BDF, 16'h0043);

        // R11 request while busy is ignored
        @(negedge clk);
        wr_count = 0;
        cmd_op = 3'd0; cmd_sn = sns[NREC-1]; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        cmd_op = 3'd4; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        check(found && rec_idx == 4'(exp_find(sns[NREC-1])), "R11 busy find result",
              {27'd0, found, rec_idx}, 32'(exp_find(sns[NREC-1])) | 32'h10);
        @(negedge clk);
        check(!done, "R11 done one cycle", 32'(done), 0);
        repeat (4) @(negedge clk);
        check(!busy && wr_count == 0, "R11 ignored request", 32'(wr_count) | {31'd0, busy}, 0);
        mem_cmp("R11 image unchanged");

        check(clash == 0, "R12 rd/wr overlap", 32'(clash), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule